// File: doc/BRIEF.md
# Real-Time Clock Prescaler with Periodic Interrupt

This block sits between a 32.768 kHz timebase and a real-time clock's calendar logic. A fifteen-bit binary count advances once per input clock, so its top bit completes one cycle per second. Every time the count passes the halfway point of that second, the block emits a one-cycle update strobe that the calendar uses to advance.

A 3-bit divider-control field sets the chain's state. The run code (binary 010) lets it count. Codes 110 and 111 hold it at zero. Any other code freezes it where it stands. Because counting always restarts from zero, the first update strobe arrives half a second after the chain is released.

A 4-bit rate-select field picks one stage of the count as the source of a periodic event. Each event sets a sticky flag and produces a one-cycle interrupt pulse. Reading status clears the flag.

Top module: `rtc_prescaler`

## Requirements
- R1: After reset, `sec_tick`, `pirq` and `pflag` are low, and the count is zero.
- R2: While `dctl` is 010, the count advances once per clock. `sec_tick` is a one-cycle pulse. It is first high in the cycle after the 16384th counting edge, and then every 32768 counting edges.
- R3: While `dctl` is 110 or 111, `chain_rst` is high, the count is held at zero, and neither `sec_tick` nor `pirq` pulses. Counting resumes from zero when the code changes to 010.
- R4: For `dctl` values 000, 001, 011, 100 and 101, the count holds its value and neither strobe pulses. `chain_rst` is low.
- R5: For `rsel` value n in 1..15, a periodic event falls on every 2^n counting edges. The first event falls after 2^(n-1) counting edges from zero, that is, after half a period. Each event raises `pirq` in the following cycle.
- R6: `rsel` equal to 0 suppresses all periodic events.
- R7: `pflag` is sticky. It stays high until a clock edge at which `stat_rd` is high, and it clears at that edge. An event at the same edge keeps it set.
- R8: `pirq` is a one-cycle pulse that coincides with `pflag` being set by an event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 32.768 kHz timebase |
| rst_n | input | 1 | Asynchronous reset, active low |
| dctl | input | 3 | Divider control: 010 run, 11x hold at zero, others freeze |
| rsel | input | 4 | Periodic rate select, 0 disables |
| stat_rd | input | 1 | Status read strobe that clears the flag |
| sec_tick | output | 1 | One-cycle 1 Hz update strobe |
| pflag | output | 1 | Sticky periodic flag |
| pirq | output | 1 | One-cycle periodic interrupt pulse |
| chain_rst | output | 1 | High while the chain is held at zero |

## Verification
The chain is exercised with the slowest rate over one and a half seconds of counting. This separates the half-second first update from the full-second repeat, and it shows the slowest tap lining up with the update strobe. A fast rate is run with the status read held high. This shows whether a coincident set beats the clear and whether the flag falls when events stop. Runs of hold codes, freeze codes and a zero rate select between active runs show whether counting restarts from zero or resumes from the frozen value, and whether any strobe leaks while the chain is idle.

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
  parameter int STAGES = 15,
  parameter int RSW    = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [2:0]     dctl,
  input  logic [RSW-1:0] rsel,
  input  logic           stat_rd,
  output logic           sec_tick,
  output logic           pflag,
  output logic           pirq,
  output logic           chain_rst
);
  localparam logic [2:0]        RUN_CODE = 3'b010;
  localparam logic [STAGES-1:0] ONE      = 1;
  localparam logic [STAGES-1:0] SEC_PRE  = {1'b0, {(STAGES-1){1'b1}}};
  localparam logic [RSW-1:0]    RMAX     = RSW'(STAGES);

  logic [STAGES-1:0] cnt;
  logic [STAGES-1:0] lomask, fullmask;
  logic              run, sec_hit, tap_en, tap_hit;

  assign run       = (dctl == RUN_CODE);
  assign chain_rst = (dctl[2:1] == 2'b11);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)         cnt <= '0;
    else if (chain_rst) cnt <= '0;
    else if (run)       cnt <= cnt + ONE;

  assign sec_hit  = run && (cnt == SEC_PRE);
  assign tap_en   = (rsel != '0) && (rsel <= RMAX);
  assign lomask   = tap_en ? ((ONE << (rsel - RSW'(1))) - ONE) : '0;
  assign fullmask = {lomask[STAGES-2:0], 1'b1};
  assign tap_hit  = run && tap_en && ((cnt & fullmask) == lomask);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sec_tick <= 1'b0;
      pirq     <= 1'b0;
      pflag    <= 1'b0;
    end else begin
      sec_tick <= sec_hit;
      pirq     <= tap_hit;
      pflag    <= tap_hit | (pflag & ~stat_rd);
    end
endmodule

// File: rtl/rtc_prescaler_chk.sv
module rtc_prescaler_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] dctl,
  input logic [3:0] rsel,
  input logic       stat_rd,
  input logic       sec_tick,
  input logic       pflag,
  input logic       pirq,
  input logic       chain_rst
);
  assert_single_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
    sec_tick |=> !sec_tick);

  assert_held_silent_R3: assert property (@(posedge clk) disable iff (!rst_n)
    chain_rst |=> (!sec_tick && !pirq));

  assert_frozen_silent_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!chain_rst && dctl != 3'b010) |=> (!sec_tick && !pirq));

  assert_rate_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rsel == 4'd0) |=> !pirq);

  assert_flag_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (pflag && !stat_rd) |=> pflag);

  assert_read_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    stat_rd |=> (pflag == pirq));

  assert_pulse_sets_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    pirq |-> pflag);

  assert_flag_rise_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pflag) |-> pirq);
endmodule

bind rtc_prescaler rtc_prescaler_chk u_chk (.*);

// File: tb/rtc_prescaler_bench.sv
module rtc_prescaler_bench;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic       rst_n;
  logic [2:0] dctl;
  logic [3:0] rsel;
  logic       stat_rd;
  logic       sec_tick, pflag, pirq, chain_rst;

  rtc_prescaler u_rtc_prescaler (
    .clk(clk), .rst_n(rst_n), .dctl(dctl), .rsel(rsel), .stat_rd(stat_rd),
    .sec_tick(sec_tick), .pflag(pflag), .pirq(pirq), .chain_rst(chain_rst)
  );

  int compared = 0, mismatched = 0, sec_seen = 0;
  bit done = 0;

  int m_cnt;
  bit m_sec, m_irq, m_flag;

  always @(posedge clk or negedge rst_n) begin
    bit hs, hp;
    int r;
    hs = 0; hp = 0; r = int'(rsel);
    if (!rst_n) begin
      m_cnt = 0; m_sec = 0; m_irq = 0; m_flag = 0;
    end else begin
      if (dctl == 3'd6 || dctl == 3'd7) m_cnt = 0;
      else if (dctl == 3'd2) begin
        m_cnt = (m_cnt + 1) % 32768;
        hs = (m_cnt == 16384);
        if (r != 0) hp = ((m_cnt % (1 << r)) == (1 << (r - 1)));
      end
      m_sec  = hs;
      m_irq  = hp;
      m_flag = hp || (m_flag && !stat_rd);
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s at %0t: actual %0d expected %0d", req, $time, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n && !done) begin
    check(sec_tick == m_sec, "R2 sec_tick", sec_tick, m_sec);
    check(pirq == m_irq, "R5/R6/R8 pirq", pirq, m_irq);
    check(pflag == m_flag, "R7 pflag", pflag, m_flag);
    check(chain_rst == (dctl[2:1] == 2'b11), "R3/R4 chain_rst", chain_rst, dctl[2:1] == 2'b11);
    if (sec_tick) sec_seen++;
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  endtask

  initial begin
    #(8 * 190000);
    compared++; mismatched++;
    $display("FAIL watchdog: run did not complete");
    finish_run();
  end

  initial begin
    rst_n = 0; dctl = 3'b000; rsel = 4'd0; stat_rd = 0;
    step(3);
    rst_n = 1;
    step(1);
    // R1: outputs quiet after reset
    check(!sec_tick && !pirq && !pflag, "R1 reset outputs", {sec_tick, pirq, pflag}, 0);

    // R3: hold code keeps chain at zero
    dctl = 3'b110; step(10);
    check(chain_rst, "R3 chain_rst asserted", chain_rst, 1);

    // R2, R5: slowest rate, first update at half second
    dctl = 3'b010; rsel = 4'd15; sec_seen = 0;
    step(16384);
    check(sec_tick && pirq, "R2 first tick at half period", {sec_tick, pirq}, 3);
    step(50000 - 16384);
    check(sec_seen == 2, "R2 tick count in 50000 cycles", sec_seen, 2);
    check(pflag, "R7 flag still set", pflag, 1);

    // R7: read clears flag
    stat_rd = 1; step(1); stat_rd = 0;
    check(!pflag, "R7 flag cleared by read", pflag, 0);

    // R3: restart from zero, fast rate with read held high
    dctl = 3'b111; step(5);
    dctl = 3'b010; rsel = 4'd3; stat_rd = 1;
    step(100);
    stat_rd = 0; step(20);

    // R4: frozen codes hold count and flag
    dctl = 3'b000; step(200);
    check(pflag, "R4 frozen keeps flag", pflag, 1);
    dctl = 3'b101; step(50);
    check(!chain_rst, "R4 freeze code not a reset", chain_rst, 0);
    dctl = 3'b010; step(30);

    // R6: rate select zero
    stat_rd = 1; step(1); stat_rd = 0;
    rsel = 4'd0; step(1000);
    check(!pflag, "R6 no flag with rate off", pflag, 0);

    // R5: fastest rate
    rsel = 4'd1; step(20);
    dctl = 3'b011; step(20);
    dctl = 3'b010; rsel = 4'd7; step(400);
    step(2);
    finish_run();
  end
endmodule